// File: doc/BRIEF.md
# I2C Slave Controller with FIFO-Gated Responses

This block answers as a slave on a two-wire I2C bus. On the system side it connects to plain byte FIFOs. It passes SCL and SDA through a short synchroniser, finds start and stop conditions, and compares each address byte against a 7-bit own address. When the master writes, every data byte is acknowledged and pushed into a receive FIFO. When the master reads, bytes are taken from a transmit FIFO and shifted onto the bus. SDA is driven through an open-drain enable only.

The block does nothing on the bus until software pulses the arm input once. Three interrupt pulses, each with its own enable bit, tell software about the end of a reception, the end of a transmission, and a read request that could not be served. Two cases change how the block acknowledges. A read address is acknowledged only when the transmit FIFO already holds a byte. A receive byte that finds the FIFO full is refused. If the master keeps reading after the transmit FIFO has run dry, the slave sends all-ones until the transfer ends.

Top module: `i2c_fifo_slave`

## Requirements
- R1: After reset, sda_oe, rx_push, tx_pop and all three interrupt outputs are low, and the block stays silent on the bus until arm has been pulsed.
- R2: Before the first arm pulse, a transfer to the own address gets no acknowledge and pushes no byte.
- R3: The address byte arrives MSB first as seven address bits followed by a direction bit (1 = read). On a match the slave pulls SDA low (sda_oe = 1) for the ninth clock. On a mismatch it stays released until the next start or stop.
- R4: During a master write, each data byte is assembled MSB first, pushed once through rx_push with the byte on rx_data, and acknowledged.
- R5: If rx_full is high when the eighth bit of a data byte is sampled, that byte is neither pushed nor acknowledged. The receive interrupt pulses, and the slave ignores the bus until the next start or stop.
- R6: A write transfer that has passed its address acknowledge raises the receive interrupt once when the next start or stop ends it.
- R7: A read address that matches is acknowledged only if tx_empty is low. Otherwise it is not acknowledged and the transmit-error interrupt pulses.
- R8: Read data is taken from tx_data, shifted out MSB first with the first bit driven at the SCL falling edge that ends the address acknowledge, and each byte is popped with one tx_pop pulse.
- R9: Once a byte is needed while tx_empty is high, the slave sends 0xFF for that byte and for every later byte until the next start or stop.
- R10: A NACK from the master after a read byte pulses the transmit-done interrupt, releases SDA, and ends the read.
- R11: A repeated start ends the current transfer (with its interrupt) and returns the block to address reception without a stop.
- R12: irq_en bit 0 gates irq_rx, bit 1 gates irq_tx, bit 2 gates irq_err; a cleared bit keeps that output low.
- R13: sda_oe changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | One-cycle strobe that enables bus responses |
| own_addr | input | 7 | Slave address to match |
| irq_en | input | 3 | Interrupt enables: [0] rx, [1] tx, [2] tx error |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low |
| rx_data | output | 8 | Received byte, valid with rx_push |
| rx_push | output | 1 | Write strobe into the receive FIFO |
| rx_full | input | 1 | Receive FIFO has no room |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO holds no byte |
| tx_pop | output | 1 | Removes the head byte of the transmit FIFO |
| irq_rx | output | 1 | Reception-ended pulse |
| irq_tx | output | 1 | Transmission-ended pulse |
| irq_err | output | 1 | Unserved-read pulse |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it makes a start or a stop, and that every SCL phase lasts longer than the synchroniser delay. The drive-timing and underrun properties rely on these assumptions. They also assume that the transmit FIFO changes head only through tx_pop or through a push. The bench master holds each SCL phase for ten clocks and moves SDA only at low phases or inside its start and stop tasks. Its FIFO models pop only on tx_pop, so the stimulus stays inside these limits.

// File: rtl/i2c_fifo_slave.sv
module i2c_fifo_slave #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic [6:0] own_addr,
  input  logic [2:0] irq_en,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic       rx_push,
  input  logic       rx_full,
  input  logic [7:0] tx_data,
  input  logic       tx_empty,
  output logic       tx_pop,
  output logic       irq_rx,
  output logic       irq_tx,
  output logic       irq_err
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK, S_TNXT, S_WAIT
  } st_t;

  logic [SYNC-1:0] scl_ff, sda_ff;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_c, stop_c;
  logic [7:0] nxt;

  st_t        st;
  logic [2:0] cnt;
  logic [7:0] sh;
  logic armed, rd, ph, under, wr_act, rd_act;
  logic p_rx, p_tx, p_err;

  assign scl_s    = scl_ff[SYNC-1];
  assign sda_s    = sda_ff[SYNC-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign nxt      = {sh[6:0], sda_s};

  assign irq_rx  = p_rx  & irq_en[0];
  assign irq_tx  = p_tx  & irq_en[1];
  assign irq_err = p_err & irq_en[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      armed   <= 1'b0;
      rd      <= 1'b0;
      ph      <= 1'b0;
      under   <= 1'b0;
      wr_act  <= 1'b0;
      rd_act  <= 1'b0;
      sda_oe  <= 1'b0;
      rx_data <= '0;
      rx_push <= 1'b0;
      tx_pop  <= 1'b0;
      p_rx    <= 1'b0;
      p_tx    <= 1'b0;
      p_err   <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      tx_pop  <= 1'b0;
      p_rx    <= 1'b0;
      p_tx    <= 1'b0;
      p_err   <= 1'b0;
      if (arm) armed <= 1'b1;

      if (armed && (start_c || stop_c)) begin
        p_rx   <= wr_act;
        p_tx   <= rd_act;
        wr_act <= 1'b0;
        rd_act <= 1'b0;
        under  <= 1'b0;
        sda_oe <= 1'b0;
        ph     <= 1'b0;
        cnt    <= '0;
        st     <= start_c ? S_ADDR : S_IDLE;
      end else begin
        case (st)
          S_ADDR: if (scl_rise) begin
            sh <= nxt;
            if (cnt == 3'd7) begin
              cnt <= '0;
              ph  <= 1'b0;
              rd  <= nxt[0];
              if (nxt[7:1] != own_addr) st <= S_WAIT;
              else if (nxt[0] && tx_empty) begin
                p_err <= 1'b1;
                st    <= S_WAIT;
              end else st <= S_AACK;
            end else cnt <= cnt + 3'd1;
          end

          S_AACK: if (scl_fall) begin
            if (!ph) begin
              sda_oe <= 1'b1;
              ph     <= 1'b1;
            end else begin
              ph  <= 1'b0;
              cnt <= '0;
              if (rd) begin
                rd_act <= 1'b1;
                st     <= S_TX;
                if (!tx_empty) begin
                  sh     <= tx_data;
                  sda_oe <= ~tx_data[7];
                  tx_pop <= 1'b1;
                end else begin
                  sh     <= 8'hFF;
                  sda_oe <= 1'b0;
                  under  <= 1'b1;
                end
              end else begin
                wr_act <= 1'b1;
                sda_oe <= 1'b0;
                st     <= S_RX;
              end
            end
          end

          S_RX: if (scl_rise) begin
            sh <= nxt;
            if (cnt == 3'd7) begin
              cnt <= '0;
              if (rx_full) begin
                p_rx   <= 1'b1;
                wr_act <= 1'b0;
                st     <= S_WAIT;
              end else begin
                rx_data <= nxt;
                rx_push <= 1'b1;
                ph      <= 1'b0;
                st      <= S_RACK;
              end
            end else cnt <= cnt + 3'd1;
          end

          S_RACK: if (scl_fall) begin
            sda_oe <= ~ph;
            ph     <= ~ph;
            if (ph) st <= S_RX;
          end

          S_TX: begin
            if (scl_rise) begin
              if (cnt == 3'd7) begin
                cnt <= '0;
                ph  <= 1'b0;
                st  <= S_TACK;
              end else cnt <= cnt + 3'd1;
            end
            if (scl_fall) begin
              sh     <= sh << 1;
              sda_oe <= ~sh[6];
            end
          end

          S_TACK: begin
            if (scl_fall && !ph) begin
              sda_oe <= 1'b0;
              ph     <= 1'b1;
            end
            if (scl_rise && ph) begin
              if (sda_s) begin
                p_tx   <= 1'b1;
                rd_act <= 1'b0;
                st     <= S_WAIT;
              end else st <= S_TNXT;
            end
          end

          S_TNXT: if (scl_fall) begin
            cnt <= '0;
            st  <= S_TX;
            if (!tx_empty && !under) begin
              sh     <= tx_data;
              sda_oe <= ~tx_data[7];
              tx_pop <= 1'b1;
            end else begin
              sh     <= 8'hFF;
              sda_oe <= 1'b0;
              under  <= 1'b1;
            end
          end

          default: ;
        endcase
      end
    end
  end

endmodule

module i2c_fifo_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       armed,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       rx_push,
  input logic       rx_full,
  input logic       tx_pop,
  input logic       tx_empty,
  input logic       under,
  input logic       in_tx,
  input logic       irq_rx,
  input logic       irq_tx,
  input logic       irq_err
);

  a_r1_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!sda_oe && !rx_push && !tx_pop));

  a_r5_push_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !$past(rx_full));

  a_r8_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !$past(tx_empty));

  a_r9_underrun_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (under && in_tx) |-> !sda_oe);

  a_r12_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_rx, irq_tx, irq_err}));

  a_r13_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

endmodule

bind i2c_fifo_slave i2c_fifo_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .scl_s(scl_s), .sda_oe(sda_oe),
  .rx_push(rx_push), .rx_full(rx_full), .tx_pop(tx_pop), .tx_empty(tx_empty),
  .under(under), .in_tx(st == S_TX), .irq_rx(irq_rx), .irq_tx(irq_tx),
  .irq_err(irq_err)
);

// File: tb/test_i2c_fifo_slave.sv
module test_i2c_fifo_slave;
  localparam int Q = 10;
  localparam logic [6:0] ADR = 7'h52;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0;
  logic [2:0] irq_en = 3'b111;
  logic scl_m = 1'b1, sda_m = 1'b1, rx_full = 1'b0;
  logic sda_oe, rx_push, tx_pop, irq_rx, irq_tx, irq_err;
  logic [7:0] rx_data;
  logic tx_empty_b = 1'b1;
  logic [7:0] tx_data_b = 8'h00;
  logic sda_bus;

  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int n_rx = 0, n_tx = 0, n_err = 0, oe_bad = 0;
  int checks = 0, fails = 0;
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_fifo_slave i_i2c_fifo_slave (
    .clk(clk), .rst_n(rst_n), .arm(arm), .own_addr(ADR), .irq_en(irq_en),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe), .rx_data(rx_data),
    .rx_push(rx_push), .rx_full(rx_full), .tx_data(tx_data_b),
    .tx_empty(tx_empty_b), .tx_pop(tx_pop), .irq_rx(irq_rx),
    .irq_tx(irq_tx), .irq_err(irq_err)
  );

  always @(posedge clk) begin
    if (rx_push) rxq.push_back(rx_data);
    if (irq_rx) n_rx++;
    if (irq_tx) n_tx++;
    if (irq_err) n_err++;
    if (tx_pop) begin
      void'(txq.pop_front());
      tx_empty_b <= (txq.size() == 0);
      tx_data_b  <= (txq.size() != 0) ? txq[0] : 8'h00;
    end
  end

  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl_m) oe_bad++;
    prev_oe = sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] b);
    txq.push_back(b);
    tx_empty_b = 1'b0;
    tx_data_b  = txq[0];
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
    sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold(); hold();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; hold(); scl_m = 1'b1; hold(); hold(); scl_m = 1'b0; hold();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); b = sda_bus; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(x);
    ack = ~x;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      rbit(x);
      d[i] = x;
    end
    wbit(~ack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int r0, t0, e0;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1", {sda_oe, rx_push, tx_pop, irq_rx, irq_tx, irq_err}, 0);

    // R2 unarmed
    bus_start(); wbyte({ADR, 1'b0}, ack); wbyte(8'h12, b[0]); bus_stop();
    chk("R2 ack", ack, 0);
    chk("R2 push", rxq.size(), 0);

    arm = 1'b1; @(negedge clk); arm = 1'b0;

    // R3/R4/R6 write
    r0 = n_rx;
    bus_start(); wbyte({ADR, 1'b0}, ack);
    chk("R3 addr ack", ack, 1);
    wbyte(8'hA5, ack); chk("R4 ack0", ack, 1);
    wbyte(8'h3C, ack); chk("R4 ack1", ack, 1);
    wbyte(8'h01, ack); chk("R4 ack2", ack, 1);
    chk("R6 no irq mid", n_rx - r0, 0);
    bus_stop();
    chk("R4 count", rxq.size(), 3);
    if (rxq.size() == 3) begin
      chk("R4 b0", rxq[0], 8'hA5);
      chk("R4 b1", rxq[1], 8'h3C);
      chk("R4 b2", rxq[2], 8'h01);
    end
    chk("R6 irq", n_rx - r0, 1);
    rxq.delete();

    // R3 mismatch
    r0 = n_rx;
    bus_start(); wbyte({ADR ^ 7'h01, 1'b0}, ack); wbyte(8'h44, b[0]); bus_stop();
    chk("R3 mismatch nack", ack, 0);
    chk("R3 no push", rxq.size(), 0);
    chk("R3 no irq", n_rx - r0, 0);

    // R5 overrun
    r0 = n_rx;
    bus_start(); wbyte({ADR, 1'b0}, ack);
    wbyte(8'h77, ack); chk("R5 first ack", ack, 1);
    rx_full = 1'b1;
    wbyte(8'h88, ack); chk("R5 overrun nack", ack, 0);
    rx_full = 1'b0;
    chk("R5 irq at nack", n_rx - r0, 1);
    bus_stop();
    chk("R5 irq once", n_rx - r0, 1);
    chk("R5 pushed", rxq.size(), 1);
    if (rxq.size() == 1) chk("R5 byte", rxq[0], 8'h77);
    rxq.delete();

    // R7 empty read
    e0 = n_err;
    bus_start(); wbyte({ADR, 1'b1}, ack); bus_stop();
    chk("R7 empty nack", ack, 0);
    chk("R7 err irq", n_err - e0, 1);

    // R8/R10 read
    t0 = n_tx;
    push_tx(8'hC3); push_tx(8'h5A);
    bus_start(); wbyte({ADR, 1'b1}, ack);
    chk("R7 ready ack", ack, 1);
    rbyte(b, 1'b1); chk("R8 byte0", b, 8'hC3);
    rbyte(b, 1'b0); chk("R8 byte1", b, 8'h5A);
    chk("R10 released", sda_oe, 0);
    chk("R10 irq", n_tx - t0, 1);
    bus_stop();
    chk("R10 irq once", n_tx - t0, 1);
    chk("R8 popped", txq.size(), 0);

    // R9 underrun
    t0 = n_tx;
    push_tx(8'h96);
    bus_start(); wbyte({ADR, 1'b1}, ack);
    rbyte(b, 1'b1); chk("R8 byte", b, 8'h96);
    rbyte(b, 1'b1); chk("R9 ones0", b, 8'hFF);
    push_tx(8'h00);
    rbyte(b, 1'b0); chk("R9 ones1", b, 8'hFF);
    bus_stop();
    chk("R9 tx irq", n_tx - t0, 1);
    chk("R9 no pop", txq.size(), 1);
    txq.delete(); tx_empty_b = 1'b1; tx_data_b = 8'h00;

    // R11 repeated start
    r0 = n_rx; t0 = n_tx;
    push_tx(8'h4E);
    bus_start(); wbyte({ADR, 1'b0}, ack); wbyte(8'h11, ack);
    bus_start();
    chk("R11 rx irq", n_rx - r0, 1);
    wbyte({ADR, 1'b1}, ack); chk("R11 addr ack", ack, 1);
    rbyte(b, 1'b0); chk("R11 data", b, 8'h4E);
    bus_stop();
    chk("R11 tx irq", n_tx - t0, 1);
    chk("R11 push", rxq.size(), 1);
    rxq.delete();

    // R12 masks
    irq_en = 3'b000;
    r0 = n_rx; e0 = n_err;
    bus_start(); wbyte({ADR, 1'b0}, ack); wbyte(8'h22, ack); bus_stop();
    bus_start(); wbyte({ADR, 1'b1}, ack); bus_stop();
    chk("R12 rx masked", n_rx - r0, 0);
    chk("R12 err masked", n_err - e0, 0);
    chk("R12 data still stored", rxq.size(), 1);
    irq_en = 3'b111;

    chk("R13 drive on low", oe_bad, 0);
    finish_run();
  end
endmodule